// File: doc/BRIEF.md
# Pipelined 64-bit Integer Multiplier

This unit multiplies two operands for a 64-bit integer pipeline. The issuing stage widens both operands to 65 bits before they arrive. A signed 64-bit value gains a copy of its sign bit, and an unsigned one gains a zero. In 32-bit mode a signed value is sign-extended from bit 31, and an unsigned one is zero-extended above bit 31. Because of this, the unit only ever multiplies two 65-bit signed numbers. One datapath therefore serves both the signed and the unsigned instruction forms.

A one-cycle issue strobe starts an operation. It carries the operands, a 2-bit form code and the 32-bit-mode flag. A fixed number of cycles later the unit raises a one-cycle result strobe, together with a 64-bit result word and an overflow flag. The form code picks one of three results from the full 130-bit product: the low 64 bits, the high 64 bits, or the high 32-bit half of the low word copied into both halves of the result.

The unit holds at most one operation at a time. The issuer waits for the result strobe before it issues again.

Top module: `mulx_unit`

## Requirements
- R1: A synchronous reset clears the result strobe and every internal stage valid bit. A reset that arrives while an operation is in flight cancels that operation, so no result strobe follows it.
- R2: When `in_valid` is sampled high at a rising edge, `out_valid` is high during the 4th cycle after that edge and only in that cycle.
- R3: Form code 2'b00 (low) returns bits 63:0 of the 130-bit signed product of the two 65-bit operands.
- R4: Form code 2'b01 (high) returns bits 127:64 of that product.
- R5: Form code 2'b10 (high word) returns product bits 63:32 in both result bits 63:32 and result bits 31:0.
- R6: With form code 2'b00 and `in_w32` low, `out_ovf` is set exactly when the product lies outside the signed 64-bit range [-2^63, 2^63-1].
- R7: With form code 2'b00 and `in_w32` high, `out_ovf` is set exactly when the product lies outside the signed 32-bit range [-2^31, 2^31-1].
- R8: With form code 2'b01 or 2'b10, `out_ovf` is 0.
- R9: The operands, form code and mode flag are sampled only in the cycle that `in_valid` is high. Changing them while an operation is in flight does not change its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Starts an operation; one cycle per operation |
| in_a | input | 65 | First operand, already widened by the issuer |
| in_b | input | 65 | Second operand, already widened by the issuer |
| in_op | input | 2 | Result form: 00 low, 01 high, 10 high word |
| in_w32 | input | 1 | 32-bit mode; selects the 32-bit overflow range |
| out_valid | output | 1 | One-cycle strobe that marks a result |
| out_data | output | 64 | Result word, meaningful while `out_valid` is high |
| out_ovf | output | 1 | Overflow flag, meaningful while `out_valid` is high |

## Verification
The bench targets these corner cases:
- The most negative 64-bit value squared, and the all-ones unsigned value squared. A datapath that dropped the 65th operand bit would return the wrong high half for these.
- Products that sit exactly on the signed 32-bit and signed 64-bit range limits, and products one step beyond them. An overflow test that checked one bit too few or too many would be wrong by one at these points.
- Operands scrambled right after issue. A unit that read its inputs later than the issue cycle would return a product of the garbage values.
- A reset in mid-flight. A unit that did not clear its stage valid bits would still raise a result strobe after the reset.

// File: rtl/mulx_pkg.sv
package mulx_pkg;
   // result form selector; values are fixed by the issuing stage
   typedef enum logic [1:0] {
      MOP_LO64 = 2'b00,
      MOP_HI64 = 2'b01,
      MOP_HI32 = 2'b10,
      MOP_RSVD = 2'b11
   } mulx_op_e;
endpackage

// File: rtl/mulx_in_stage.sv
module mulx_in_stage
   import mulx_pkg::*;
#(
   parameter int OPW = 65
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           vld_i,
   input  logic [OPW-1:0] a_i,
   input  logic [OPW-1:0] b_i,
   input  mulx_op_e       op_i,
   input  logic           w32_i,
   output logic           vld_o,
   output logic [OPW-1:0] a_o,
   output logic [OPW-1:0] b_o,
   output mulx_op_e       op_o,
   output logic           w32_o
);
   always_ff @(posedge clk) begin
      if (rst) vld_o <= 1'b0;
      else     vld_o <= vld_i;
   end

   // operands captured only on issue, held while in flight
   always_ff @(posedge clk) begin
      if (vld_i) begin
         a_o   <= a_i;
         b_o   <= b_i;
         op_o  <= op_i;
         w32_o <= w32_i;
      end
   end

   // R9
   a_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !vld_i |=> $stable(a_o) && $stable(b_o));
endmodule

// File: rtl/mulx_prod_pipe.sv
module mulx_prod_pipe
   import mulx_pkg::*;
#(
   parameter int OPW    = 65,
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              vld_i,
   input  logic [OPW-1:0]    a_i,
   input  logic [OPW-1:0]    b_i,
   input  mulx_op_e          op_i,
   input  logic              w32_i,
   output logic [STAGES-1:0] stg_vld_o,
   output logic              vld_o,
   output logic [2*OPW-1:0]  prod_o,
   output mulx_op_e          op_o,
   output logic              w32_o
);
   localparam int PROD_W = 2 * OPW;

   logic signed [PROD_W-1:0] a_ext, b_ext, prod_c;
   logic [STAGES-1:0]        vld_q;
   logic [PROD_W-1:0]        prod_q [STAGES];
   mulx_op_e                 op_q   [STAGES];
   logic                     w32_q  [STAGES];

   always_comb begin
      a_ext  = {{OPW{a_i[OPW-1]}}, a_i};
      b_ext  = {{OPW{b_i[OPW-1]}}, b_i};
      prod_c = a_ext * b_ext;
   end

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (rst) vld_q <= '0;
            else     vld_q <= vld_i;
         end
      end else begin : g_chain
         always_ff @(posedge clk) begin
            if (rst) vld_q <= '0;
            else     vld_q <= {vld_q[STAGES-2:0], vld_i};
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      prod_q[0] <= prod_c;
      op_q[0]   <= op_i;
      w32_q[0]  <= w32_i;
      for (int s = STAGES - 1; s > 0; s--) begin
         prod_q[s] <= prod_q[s-1];
         op_q[s]   <= op_q[s-1];
         w32_q[s]  <= w32_q[s-1];
      end
   end

   assign stg_vld_o = vld_q;
   assign vld_o     = vld_q[STAGES-1];
   assign prod_o    = prod_q[STAGES-1];
   assign op_o      = op_q[STAGES-1];
   assign w32_o     = w32_q[STAGES-1];

   // R2
   stage_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(vld_q));
endmodule

// File: rtl/mulx_result_fmt.sv
module mulx_result_fmt
   import mulx_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                vld_i,
   input  logic [2*DATA_W+1:0] prod_i,
   input  mulx_op_e            op_i,
   input  logic                w32_i,
   output logic                vld_o,
   output logic [DATA_W-1:0]   data_o,
   output logic                ovf_o
);
   localparam int PROD_W = 2 * DATA_W + 2;
   localparam int HALF   = DATA_W / 2;

   logic [PROD_W-DATA_W:0] top64;
   logic [PROD_W-HALF:0]   top32;
   logic                   fits64, fits32;
   logic [DATA_W-1:0]      data_c;
   logic                   ovf_c;
   mulx_op_e               op_q;

   // a value fits when all bits from the sign position upward agree
   always_comb begin
      top64  = prod_i[PROD_W-1:DATA_W-1];
      top32  = prod_i[PROD_W-1:HALF-1];
      fits64 = (&top64) | !(|top64);
      fits32 = (&top32) | !(|top32);
      unique case (op_i)
         MOP_HI64: begin
            data_c = prod_i[2*DATA_W-1:DATA_W];
            ovf_c  = 1'b0;
         end
         MOP_HI32: begin
            data_c = {2{prod_i[DATA_W-1:HALF]}};
            ovf_c  = 1'b0;
         end
         default: begin
            data_c = prod_i[DATA_W-1:0];
            ovf_c  = w32_i ? !fits32 : !fits64;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) vld_o <= 1'b0;
      else     vld_o <= vld_i;
   end

   always_ff @(posedge clk) begin
      if (vld_i) begin
         data_o <= data_c;
         ovf_o  <= ovf_c;
         op_q   <= op_i;
      end
   end

   // R5
   hi32_dup_chk: assert property (@(posedge clk) disable iff (rst)
      vld_o && (op_q == MOP_HI32) |-> data_o[DATA_W-1:HALF] == data_o[HALF-1:0]);

   // R8
   ovf_form_chk: assert property (@(posedge clk) disable iff (rst)
      vld_o && ovf_o |-> (op_q == MOP_LO64) || (op_q == MOP_RSVD));
endmodule

// File: rtl/mulx_unit.sv
module mulx_unit
   import mulx_pkg::*;
#(
   parameter int DATA_W  = 64,
   parameter int LATENCY = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [DATA_W:0]   in_a,
   input  logic [DATA_W:0]   in_b,
   input  logic [1:0]        in_op,
   input  logic              in_w32,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_ovf
);
   localparam int OPW     = DATA_W + 1;
   localparam int PROD_W  = 2 * OPW;
   localparam int PSTAGES = LATENCY - 2;
   localparam int CW      = $clog2(LATENCY + 2);

   generate
      if (LATENCY < 3) begin : g_bad_lat
         $error("mulx_unit: LATENCY must be at least 3");
      end
      if (DATA_W % 2 != 0) begin : g_bad_width
         $error("mulx_unit: DATA_W must be even");
      end
   endgenerate

   mulx_op_e           op_c;
   logic               s1_vld, s1_w32, pp_vld, pp_w32;
   logic [OPW-1:0]     s1_a, s1_b;
   mulx_op_e           s1_op, pp_op;
   logic [PSTAGES-1:0] pp_stg;
   logic [PROD_W-1:0]  pp_prod;
   logic               busy;

   assign op_c = mulx_op_e'(in_op);
   assign busy = s1_vld | (|pp_stg);

   mulx_in_stage #(.OPW(OPW)) u_in (
      .clk(clk), .rst(rst), .vld_i(in_valid), .a_i(in_a), .b_i(in_b),
      .op_i(op_c), .w32_i(in_w32), .vld_o(s1_vld), .a_o(s1_a), .b_o(s1_b),
      .op_o(s1_op), .w32_o(s1_w32)
   );

   mulx_prod_pipe #(.OPW(OPW), .STAGES(PSTAGES)) u_pipe (
      .clk(clk), .rst(rst), .vld_i(s1_vld), .a_i(s1_a), .b_i(s1_b),
      .op_i(s1_op), .w32_i(s1_w32), .stg_vld_o(pp_stg), .vld_o(pp_vld),
      .prod_o(pp_prod), .op_o(pp_op), .w32_o(pp_w32)
   );

   mulx_result_fmt #(.DATA_W(DATA_W)) u_fmt (
      .clk(clk), .rst(rst), .vld_i(pp_vld), .prod_i(pp_prod), .op_i(pp_op),
      .w32_i(pp_w32), .vld_o(out_valid), .data_o(out_data), .ovf_o(out_ovf)
   );

   // cycles since the last issue, for the latency check
   logic [CW-1:0] since_issue;
   always_ff @(posedge clk) begin
      if (rst)
         since_issue <= '0;
      else if (in_valid)
         since_issue <= CW'(1);
      else if (since_issue != '0 && since_issue <= CW'(LATENCY))
         since_issue <= since_issue + CW'(1);
   end

   // R1
   rst_clr_chk: assert property (@(posedge clk) rst |=> !out_valid && !busy);

   // R2
   out_lat_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> since_issue == CW'(LATENCY));

   // R2
   issue_idle_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> !busy);
endmodule

// File: tb/mulx_unit_tb.sv
`timescale 1ns/1ps
module mulx_unit_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [64:0] in_a = '0, in_b = '0;
   logic [1:0]  in_op = 2'b00;
   logic        in_w32 = 1'b0;
   logic        out_valid;
   logic [63:0] out_data;
   logic        out_ovf;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   mulx_unit u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
      .in_op(in_op), .in_w32(in_w32), .out_valid(out_valid),
      .out_data(out_data), .out_ovf(out_ovf)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // widening done by the issuer
   function automatic logic [64:0] widen(input logic [63:0] v, input bit sgn, input bit w32);
      if (w32) return sgn ? {{33{v[31]}}, v[31:0]} : {33'b0, v[31:0]};
      return sgn ? {v[63], v} : {1'b0, v};
   endfunction

   // reference: range comparisons on the full signed product
   function automatic logic [64:0] model(input logic [64:0] a, input logic [64:0] b,
                                         input logic [1:0] op, input bit w32);
      logic signed [129:0] pa, pb, p, lim;
      logic [63:0] d;
      logic        o;
      pa  = $signed(a);
      pb  = $signed(b);
      p   = pa * pb;
      lim = w32 ? (130'sd1 <<< 31) : (130'sd1 <<< 63);
      o   = 1'b0;
      case (op)
         2'b01:   d = p[127:64];
         2'b10:   d = {p[63:32], p[63:32]};
         default: begin
            d = p[63:0];
            o = (p > lim - 130'sd1) || (p < -lim);
         end
      endcase
      return {o, d};
   endfunction

   task automatic do_op(input logic [64:0] a, input logic [64:0] b,
                        input logic [1:0] op, input bit w32);
      logic [64:0] exp;
      bit quiet;
      string dtag, otag;
      exp  = model(a, b, op, w32);
      dtag = (op == 2'b01) ? "R4" : (op == 2'b10) ? "R5" : "R3";
      otag = (op != 2'b00) ? "R8" : (w32 ? "R7" : "R6");
      @(negedge clk);
      in_valid = 1'b1; in_a = a; in_b = b; in_op = op; in_w32 = w32;
      @(negedge clk);
      // R9: scramble inputs while the operation is in flight
      in_valid = 1'b0;
      in_a = {$urandom, $urandom, $urandom};
      in_b = {$urandom, $urandom, $urandom};
      in_op = 2'($urandom); in_w32 = 1'($urandom);
      quiet = !out_valid;
      repeat (2) begin
         @(negedge clk);
         quiet &= !out_valid;
      end
      @(negedge clk);
      check(quiet && out_valid, "R2", "strobe in 4th cycle only", {63'b0, out_valid}, 64'd1);
      check(out_data === exp[63:0], dtag, "result word (R9 inputs scrambled)", out_data, exp[63:0]);
      check(out_ovf === exp[64], otag, "overflow flag", {63'b0, out_ovf}, {63'b0, exp[64]});
      @(negedge clk);
      check(!out_valid, "R2", "strobe is one cycle", {63'b0, out_valid}, 64'd0);
   endtask

   function automatic logic [63:0] pick64();
      case ($urandom % 6)
         0:       return {$urandom, $urandom};
         1:       return 64'($urandom % 256);
         2:       return '1;
         3:       return 64'h8000_0000_0000_0000;
         4:       return 64'h7FFF_FFFF_FFFF_FFFF;
         default: return {32'h0, $urandom};
      endcase
   endfunction

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check(!out_valid, "R1", "idle after reset", {63'b0, out_valid}, 64'd0);

      // directed corner cases
      do_op(widen(64'h8000_0000_0000_0000, 1, 0), widen(64'h8000_0000_0000_0000, 1, 0), 2'b00, 0);
      do_op(widen(64'h8000_0000_0000_0000, 1, 0), widen(64'h8000_0000_0000_0000, 1, 0), 2'b01, 0);
      do_op(widen('1, 0, 0), widen('1, 0, 0), 2'b01, 0);
      do_op(widen('1, 0, 0), widen('1, 0, 0), 2'b00, 0);
      do_op(widen('1, 1, 0), widen('1, 1, 0), 2'b00, 0);
      do_op(widen(64'h7FFF_FFFF_FFFF_FFFF, 1, 0), widen(64'd1, 1, 0), 2'b00, 0);
      do_op(widen(64'h4000_0000_0000_0000, 1, 0), widen(64'd2, 1, 0), 2'b00, 0);
      do_op(widen(64'h7FFF_FFFF, 1, 1), widen(64'd2, 1, 1), 2'b00, 1);
      do_op(widen(64'h7FFF_FFFF, 1, 0), widen(64'd2, 1, 0), 2'b00, 0);
      do_op(widen(64'h8000_0000, 1, 1), widen(64'd1, 1, 1), 2'b00, 1);
      do_op(widen(64'h8000_0000, 1, 1), widen('1, 1, 1), 2'b00, 1);
      do_op(widen(64'hFFFF_FFFF, 0, 1), widen(64'hFFFF_FFFF, 0, 1), 2'b10, 1);
      do_op(widen(64'hFFFF_FFFF, 1, 1), widen(64'h7FFF_FFFF, 1, 1), 2'b10, 1);

      // R1: reset in mid-flight cancels the operation
      @(negedge clk);
      in_valid = 1'b1; in_a = widen(64'd5, 1, 0); in_b = widen(64'd7, 1, 0); in_op = 2'b00;
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      for (int i = 0; i < 5; i++) begin
         check(!out_valid, "R1", "no strobe after mid-flight reset", {63'b0, out_valid}, 64'd0);
         @(negedge clk);
      end

      // constrained random
      for (int k = 0; k < 200; k++) begin
         bit sa, sb, w;
         logic [1:0] op;
         sa = 1'($urandom); w = 1'($urandom);
         sb = sa;
         op = 2'($urandom % 3);
         do_op(widen(pick64(), sa, w), widen(pick64(), sb, w), op, w);
      end

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL R2 watchdog: actual=running expected=finished");
         $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule